// File: doc/BRIEF.md
# Manual Error-Insertion Trigger

This block turns a manual error request into single-shot insert commands for a transmit block. The request can come from four places: a bit owned by the transmit block itself, a bit shared by the whole port, a bit shared by the whole chip, or an external pin. Three mode bits pick one of them in a cascade. A block-level mode bit of 0 keeps the request local. Otherwise the port-level mode bit decides whether the port bit is used or the choice moves up a level. At the top level, the global mode bit chooses between the global bit and the pin.

The selected request is watched for a low-to-high change. A change arms one pending error. At the next cycle where the datapath offers an insertion opportunity, the block raises an insert pulse on every error-type line whose enable is set, then disarms. The external pin is asynchronous, so it is resynchronised by a two-flop chain before edge detection. The register bits are taken as synchronous. The block does not corrupt any data itself.

Top module: `err_inject_trigger`

## Requirements
- R1: With blk_mode_i = 0, a rising edge of blk_trig_i arms an error, whatever the other mode bits and sources do.
- R2: With blk_mode_i = 1 and port_mode_i = 0, a rising edge of port_trig_i arms an error.
- R3: With blk_mode_i = 1, port_mode_i = 1 and glb_mode_i = 0, a rising edge of glb_trig_i arms an error.
- R4: With all three mode bits at 1, a rising edge of gpio_i arms an error after passing through a two-flop synchronizer. An edge presented before clock edge k sets the pending state at edge k+2.
- R5: Edges on a source that is not currently selected arm nothing and produce no insert pulse.
- R6: insert_o[i] is high only in a cycle where opp_i is high, an error is pending and type_en_i[i] is 1. In that cycle insert_o equals type_en_i.
- R7: A rising edge seen in cycle t sets the pending state at the following clock edge. The pending state clears at the clock edge that closes the first cycle with opp_i high. It clears even when every type enable is 0, so the error is consumed without a pulse.
- R8: Any number of rising edges between two opportunities yields exactly one insertion.
- R9: With nothing pending, opp_i produces no insert pulse. A source held high after its edge arms nothing further.
- R10: During reset insert_o is 0 and nothing is pending. The edge detector's history resets to 0, so a selected source that is already high when reset ends counts as a rising edge.
- R11: If a rising edge and opp_i occur in the same cycle, that opportunity is not used, and the error fires at the next opportunity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_mode_i | input | 1 | Block-level mode: 0 selects the block bit, 1 defers to the port level |
| port_mode_i | input | 1 | Port-level mode: 0 selects the port bit, 1 defers to the global level |
| glb_mode_i | input | 1 | Global mode: 0 selects the global bit, 1 selects the pin |
| blk_trig_i | input | 1 | Block register request bit |
| port_trig_i | input | 1 | Port register request bit |
| glb_trig_i | input | 1 | Global register request bit |
| gpio_i | input | 1 | Asynchronous external request pin |
| type_en_i | input | NUM_TYPES | Per-error-type enables |
| opp_i | input | 1 | Insertion opportunity strobe |
| insert_o | output | NUM_TYPES | Per-type insert pulses |

## Verification
A register-bit edge presented in cycle t makes the pending state visible from cycle t+1. A pin edge needs two further cycles. An insert pulse appears combinationally in the same cycle as the opportunity that consumes the pending error. The bench drives inputs one time unit after the rising edge and compares insert_o against a behavioural model at every falling edge. The model keeps its pending flag and pin delay line in plain variables and updates them after each comparison, so every expected value lines up with the clock edge at which the hardware changes. Directed scenarios also count insert pulses within windows that span each source, the edge-collapse case, the same-cycle edge-and-opportunity case and the consume-without-enable case.

// File: rtl/errins_pkg.sv
package errins_pkg;

  typedef enum logic [1:0] {
    SRC_BLK  = 2'd0,
    SRC_PORT = 2'd1,
    SRC_GLB  = 2'd2,
    SRC_PIN  = 2'd3
  } trig_src_e;

  // cascade: lowest level with mode 0 owns the trigger
  function automatic trig_src_e pick_src(logic blk_mode, logic port_mode, logic glb_mode);
    if (!blk_mode)       return SRC_BLK;
    else if (!port_mode) return SRC_PORT;
    else if (!glb_mode)  return SRC_GLB;
    else                 return SRC_PIN;
  endfunction

endpackage

// File: rtl/errins_sync.sv
module errins_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[k] <= 1'b0;
        else         chain_q[k] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[k] <= 1'b0;
        else         chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/errins_src_sel.sv
module errins_src_sel
  import errins_pkg::*;
(
  input  logic blk_mode_i,
  input  logic port_mode_i,
  input  logic glb_mode_i,
  input  logic blk_trig_i,
  input  logic port_trig_i,
  input  logic glb_trig_i,
  input  logic pin_sync_i,
  output logic trig_o
);
  trig_src_e src;

  always_comb begin
    src = pick_src(blk_mode_i, port_mode_i, glb_mode_i);
    unique case (src)
      SRC_BLK:  trig_o = blk_trig_i;
      SRC_PORT: trig_o = port_trig_i;
      SRC_GLB:  trig_o = glb_trig_i;
      default:  trig_o = pin_sync_i;
    endcase
  end
endmodule

// File: rtl/errins_arm.sv
module errins_arm #(
  parameter int unsigned NUM_TYPES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trig_i,
  input  logic                 opp_i,
  input  logic [NUM_TYPES-1:0] type_en_i,
  output logic [NUM_TYPES-1:0] insert_o
);
  logic trig_q, rise, pend_q, pend_d;

  assign rise = trig_i & ~trig_q;

  // a fresh edge re-arms even while an opportunity consumes the old one
  assign pend_d = rise | (pend_q & ~opp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      pend_q <= pend_d;
    end
  end

  for (genvar i = 0; i < NUM_TYPES; i++) begin : g_type
    assign insert_o[i] = opp_i & pend_q & type_en_i[i];
  end

  // R6
  ins_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insert_o & ~type_en_i) == '0);
  // R9
  no_ins_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |-> insert_o == '0);
  // R7
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && opp_i && !rise) |=> !pend_q);
  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !opp_i) |=> pend_q);
  // R7
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(trig_i) && !$past(trig_q));
  // R9
  level_no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q && trig_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/err_inject_trigger.sv
module err_inject_trigger #(
  parameter int unsigned NUM_TYPES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 blk_mode_i,
  input  logic                 port_mode_i,
  input  logic                 glb_mode_i,
  input  logic                 blk_trig_i,
  input  logic                 port_trig_i,
  input  logic                 glb_trig_i,
  input  logic                 gpio_i,
  input  logic [NUM_TYPES-1:0] type_en_i,
  input  logic                 opp_i,
  output logic [NUM_TYPES-1:0] insert_o
);
  logic pin_sync, trig_sel;

  errins_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_i),
    .q_o    (pin_sync)
  );

  errins_src_sel u_sel (
    .blk_mode_i  (blk_mode_i),
    .port_mode_i (port_mode_i),
    .glb_mode_i  (glb_mode_i),
    .blk_trig_i  (blk_trig_i),
    .port_trig_i (port_trig_i),
    .glb_trig_i  (glb_trig_i),
    .pin_sync_i  (pin_sync),
    .trig_o      (trig_sel)
  );

  errins_arm #(.NUM_TYPES(NUM_TYPES)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_sel),
    .opp_i     (opp_i),
    .type_en_i (type_en_i),
    .insert_o  (insert_o)
  );

  // R1
  blk_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_mode_i |-> trig_sel == blk_trig_i);
  // R4
  pin_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_sync) |-> $past(gpio_i, 2));
endmodule

// File: tb/tb_err_inject_trigger.sv
`timescale 1ns/1ps
module tb_err_inject_trigger;
  localparam int NT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic blk_mode = 0, port_mode = 0, glb_mode = 0;
  logic blk_trig = 0, port_trig = 0, glb_trig = 0, gpio = 0;
  logic [NT-1:0] type_en = '0;
  logic opp = 0;
  logic [NT-1:0] insert;

  int n_run = 0, n_fail = 0;
  int pulse_cnt = 0;
  logic [NT-1:0] last_ins = '0;
  bit done = 0;

  // model state
  bit m_pend = 0, m_prev = 0, m_g1 = 0, m_g2 = 0;

  always #2 clk = ~clk;

  err_inject_trigger #(.NUM_TYPES(NT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .blk_mode_i(blk_mode), .port_mode_i(port_mode), .glb_mode_i(glb_mode),
    .blk_trig_i(blk_trig), .port_trig_i(port_trig), .glb_trig_i(glb_trig),
    .gpio_i(gpio), .type_en_i(type_en), .opp_i(opp), .insert_o(insert)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [NT-1:0] exp_ins;
    bit sel, rise;
    if (!rst_n) begin
      m_pend = 0; m_prev = 0; m_g1 = 0; m_g2 = 0;
      check("R10", int'(insert), 0);
    end else begin
      exp_ins = (opp && m_pend) ? type_en : '0;
      check("R6", int'(insert), int'(exp_ins));
      if (insert != '0) begin
        pulse_cnt++;
        last_ins = insert;
      end
      if (!blk_mode)       sel = blk_trig;
      else if (!port_mode) sel = port_trig;
      else if (!glb_mode)  sel = glb_trig;
      else                 sel = m_g2;
      rise   = sel && !m_prev;
      m_pend = rise || (m_pend && !opp);
      m_prev = sel;
      m_g2   = m_g1;
      m_g1   = gpio;
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_opp();
    opp = 1; step(); opp = 0; step();
  endtask

  task automatic set_mode(bit b, bit p, bit g);
    blk_mode = b; port_mode = p; glb_mode = g;
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R10", int'(insert), 0);
    rst_n = 1; step(2);

    // R1: block bit, other sources noisy (R5)
    set_mode(0, 1, 1); type_en = 4'b1111; step();
    pulse_cnt = 0;
    port_trig = 1; glb_trig = 1; gpio = 1; step(4);
    port_trig = 0; glb_trig = 0; gpio = 0; step(2);
    pulse_opp();
    check("R5", pulse_cnt, 0);
    blk_trig = 1; step(); blk_trig = 0; step(2);
    pulse_opp();
    check("R1", pulse_cnt, 1);
    check("R1", int'(last_ins), 15);

    // R2: port bit
    set_mode(1, 0, 0); type_en = 4'b0101; step(); pulse_cnt = 0;
    blk_trig = 1; glb_trig = 1; step(); blk_trig = 0; glb_trig = 0; step();
    pulse_opp();
    check("R5", pulse_cnt, 0);
    port_trig = 1; step(); port_trig = 0; step(2);
    pulse_opp();
    check("R2", pulse_cnt, 1);
    check("R6", int'(last_ins), 5);

    // R3: global bit
    set_mode(1, 1, 0); type_en = 4'b1010; step(); pulse_cnt = 0;
    glb_trig = 1; step(); glb_trig = 0; step(2);
    pulse_opp();
    check("R3", pulse_cnt, 1);
    check("R6", int'(last_ins), 10);

    // R4: pin through synchronizer; not ready after one cycle
    set_mode(1, 1, 1); type_en = 4'b1001; step(); pulse_cnt = 0;
    gpio = 1; step(); gpio = 0;
    pulse_opp();
    check("R4", pulse_cnt, 0);
    step(2);
    pulse_opp();
    check("R4", pulse_cnt, 1);
    check("R6", int'(last_ins), 9);

    // R8: many edges collapse
    set_mode(0, 0, 0); type_en = 4'b1111; step(); pulse_cnt = 0;
    for (int k = 0; k < 3; k++) begin
      blk_trig = 1; step(); blk_trig = 0; step();
    end
    pulse_opp(); pulse_opp();
    check("R8", pulse_cnt, 1);

    // R9: held level, opportunities without pending
    pulse_cnt = 0;
    blk_trig = 1; step(2);
    pulse_opp();
    check("R9", pulse_cnt, 1);
    pulse_opp(); pulse_opp();
    check("R9", pulse_cnt, 1);
    blk_trig = 0; step();

    // R7: consumed with all enables off
    pulse_cnt = 0;
    type_en = '0;
    blk_trig = 1; step(); blk_trig = 0; step();
    pulse_opp();
    type_en = 4'b1111;
    pulse_opp();
    check("R7", pulse_cnt, 0);

    // R11: edge coincident with opportunity
    pulse_cnt = 0;
    blk_trig = 1; opp = 1; step(); blk_trig = 0; opp = 0;
    check("R11", pulse_cnt, 0);
    step();
    pulse_opp();
    check("R11", pulse_cnt, 1);

    // R10: source high across reset release
    blk_trig = 1; rst_n = 0; step(2);
    check("R10", int'(insert), 0);
    rst_n = 1; pulse_cnt = 0; step(2);
    pulse_opp();
    check("R10", pulse_cnt, 1);
    blk_trig = 0; step(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule